// File: doc/BRIEF.md
# AXI Write Strobe-to-Size Narrower

This block sits on the write side of an AXI master, between the master and the interconnect. When a write is a single beat and its byte strobe marks one naturally aligned sub-word (a single byte, or an aligned pair of bytes), the block issues the write address as a narrow transfer. The address byte offset is taken from the position of the strobe, and the transfer size is taken from the strobe's width. In every other case the address and size pass through unchanged.

All logic is combinational. The rewrite uses the strobe that is on the write-data channel while the address channel is valid. A master must therefore present the write data together with the address for the narrowing to take effect. Every other address and data field passes through unchanged. Valid and ready are wired straight across in both directions, so the block adds no storage and no latency.

Top module: `axi_wstrb_narrower`

## Requirements
- R1: With awlen equal to 0, a strobe with exactly one bit set (0x1, 0x2, 0x4 or 0x8) drives m_awsize to 0, and m_awaddr[1:0] to the index of that bit (0, 1, 2 or 3).
- R2: With awlen equal to 0, strobe 0x3 drives m_awsize to 1 with m_awaddr[1:0] equal to 0, and strobe 0xC drives m_awsize to 1 with m_awaddr[1:0] equal to 2.
- R3: A strobe of 0 leaves m_awsize equal to s_awsize and m_awaddr equal to s_awaddr.
- R4: A full strobe 0xF, and any pattern that is not one aligned byte or one aligned byte pair (for example 0x5, 0x6, 0x7, 0xE), leaves m_awaddr and m_awsize equal to their inputs.
- R5: m_awaddr[31:2] always equals s_awaddr[31:2]. On a rewrite the low two bits are replaced by the offset, not added to it: 0x5553 with strobe 0x2 gives 0x5551.
- R6: m_awvalid equals s_awvalid, and s_awready equals m_awready, in every combination.
- R7: m_wvalid equals s_wvalid, and s_wready equals m_wready, in every combination.
- R8: awid, awlen, awburst, wdata, wstrb and wlast reach the output side unchanged.
- R9: When awlen is not 0, no rewrite happens, whatever the strobe.
- R10: The outputs follow a change of the strobe with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_awid | input | 4 | Write ID from the master |
| s_awaddr | input | 32 | Write address from the master |
| s_awlen | input | 8 | Burst length minus one |
| s_awsize | input | 3 | Transfer size code from the master |
| s_awburst | input | 2 | Burst type |
| s_awvalid | input | 1 | Address valid from the master |
| s_awready | output | 1 | Address ready to the master |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte lane strobe |
| s_wlast | input | 1 | Last beat flag |
| s_wvalid | input | 1 | Data valid from the master |
| s_wready | output | 1 | Data ready to the master |
| m_awid | output | 4 | Forwarded write ID |
| m_awaddr | output | 32 | Possibly narrowed write address |
| m_awlen | output | 8 | Forwarded burst length |
| m_awsize | output | 3 | Possibly narrowed size code |
| m_awburst | output | 2 | Forwarded burst type |
| m_awvalid | output | 1 | Forwarded address valid |
| m_awready | input | 1 | Address ready from the slave |
| m_wdata | output | 32 | Forwarded write data |
| m_wstrb | output | 4 | Forwarded strobe |
| m_wlast | output | 1 | Forwarded last flag |
| m_wvalid | output | 1 | Forwarded data valid |
| m_wready | input | 1 | Data ready from the slave |

## Verification
The bench targets the misaligned pair 0x6. A decoder that only looks at the count of strobe bits would narrow it to size 1 at a bad offset. It drives a nonzero address low part with a narrow strobe, which exposes a design that adds the offset instead of replacing it. It sends a multi-beat write with a narrow strobe, which a design without the length guard would shrink. It also covers the zero and full strobes, where an eager design would issue a wrong size. Finally, the strobe is changed between clock edges to catch any registered path.

// File: rtl/nrw_pkg.sv
package nrw_pkg;
  localparam int SIZE_W = 3;
  typedef logic [SIZE_W-1:0] axsize_t;

  // Mask of 2**lg contiguous lanes starting at lane pos.
  function automatic longint lane_mask(input int lg, input int pos);
    longint ones;
    ones = (longint'(1) << (1 << lg)) - 1;
    return ones << pos;
  endfunction
endpackage

// File: rtl/nrw_strb_decode.sv
module nrw_strb_decode
  import nrw_pkg::*;
#(
  parameter int STRB_W = 4,
  localparam int OFF_W = $clog2(STRB_W)
) (
  input  logic [STRB_W-1:0] strb,
  output logic              hit,
  output axsize_t           size,
  output logic [OFF_W-1:0]  offset
);
  // Only sizes below the full word are candidates; a full strobe is left alone.
  always_comb begin
    hit    = 1'b0;
    size   = '0;
    offset = '0;
    for (int lg = 0; lg < OFF_W; lg++) begin
      for (int pos = 0; pos < STRB_W; pos += (1 << lg)) begin
        if ({{(64-STRB_W){1'b0}}, strb} == 64'(lane_mask(lg, pos))) begin
          hit    = 1'b1;
          size   = axsize_t'(lg);
          offset = OFF_W'(pos);
        end
      end
    end
  end
endmodule

// File: rtl/nrw_aw_rewrite.sv
module nrw_aw_rewrite
  import nrw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  axsize_t           size_in,
  input  logic [7:0]        len_in,
  input  logic              hit,
  input  axsize_t           size_nar,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] addr_out,
  output axsize_t           size_out
);
  logic apply;

  always_comb begin
    apply = hit && (len_in == 8'd0);
    if (apply) begin
      addr_out = {addr_in[ADDR_W-1:OFF_W], offset};
      size_out = size_nar;
    end else begin
      addr_out = addr_in;
      size_out = size_in;
    end
  end
endmodule

// File: rtl/axi_wstrb_narrower.sv
module axi_wstrb_narrower
  import nrw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  localparam int STRB_W = DATA_W / 8,
  localparam int OFF_W  = $clog2(STRB_W)
) (
  input  logic [ID_W-1:0]   s_awid,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [7:0]        s_awlen,
  input  logic [2:0]        s_awsize,
  input  logic [1:0]        s_awburst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wlast,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [ID_W-1:0]   m_awid,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DATA_W-1:0] m_wdata,
  output logic [STRB_W-1:0] m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready
);
  logic             dec_hit;
  axsize_t          dec_size;
  logic [OFF_W-1:0] dec_off;

  nrw_strb_decode #(.STRB_W(STRB_W)) u_dec (
    .strb   (s_wstrb),
    .hit    (dec_hit),
    .size   (dec_size),
    .offset (dec_off)
  );

  nrw_aw_rewrite #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rew (
    .addr_in  (s_awaddr),
    .size_in  (s_awsize),
    .len_in   (s_awlen),
    .hit      (dec_hit),
    .size_nar (dec_size),
    .offset   (dec_off),
    .addr_out (m_awaddr),
    .size_out (m_awsize)
  );

  // Straight-through fields and handshakes.
  assign m_awid    = s_awid;
  assign m_awlen   = s_awlen;
  assign m_awburst = s_awburst;
  assign m_awvalid = s_awvalid;
  assign s_awready = m_awready;
  assign m_wdata   = s_wdata;
  assign m_wstrb   = s_wstrb;
  assign m_wlast   = s_wlast;
  assign m_wvalid  = s_wvalid;
  assign s_wready  = m_wready;
endmodule

// File: rtl/nrw_checker.sv
module nrw_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8,
  localparam int OFF_W  = $clog2(STRB_W)
) (
  input logic [ADDR_W-1:0] s_awaddr,
  input logic [7:0]        s_awlen,
  input logic [2:0]        s_awsize,
  input logic [STRB_W-1:0] s_wstrb,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic [2:0]        m_awsize,
  input logic              m_awvalid,
  input logic              m_awready
);
  // The block is purely combinational, so the checks are immediate ones on settled values.
  always_comb begin
    // R1: one lane set -> byte size, and the offset points at that lane
    if (s_awlen == 8'd0 && $onehot(s_wstrb))
      a_r1_byte_lane: assert (m_awsize == 3'd0 && s_wstrb[m_awaddr[OFF_W-1:0]] == 1'b1);
    // R2: a narrowed size covers exactly the set lanes
    if (m_awsize != s_awsize)
      a_r2_size_matches_lanes: assert ((1 << m_awsize) == $countones(s_wstrb));
    // R3: empty strobe keeps size and address
    if (s_wstrb == '0)
      a_r3_empty_strobe: assert (m_awsize == s_awsize && m_awaddr == s_awaddr);
    // R5: upper address bits never change
    a_r5_upper_addr: assert (m_awaddr[ADDR_W-1:OFF_W] == s_awaddr[ADDR_W-1:OFF_W]);
    // R9: bursts are never narrowed
    if (s_awlen != 8'd0)
      a_r9_burst_untouched: assert (m_awaddr == s_awaddr && m_awsize == s_awsize);
    // R6: handshake crosses both ways
    a_r6_aw_handshake: assert (m_awvalid == s_awvalid && s_awready == m_awready);
  end
endmodule

bind axi_wstrb_narrower nrw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_nrw_chk (
  .s_awaddr  (s_awaddr),
  .s_awlen   (s_awlen),
  .s_awsize  (s_awsize),
  .s_wstrb   (s_wstrb),
  .s_awvalid (s_awvalid),
  .s_awready (s_awready),
  .m_awaddr  (m_awaddr),
  .m_awsize  (m_awsize),
  .m_awvalid (m_awvalid),
  .m_awready (m_awready)
);

// File: tb/test_axi_wstrb_narrower.sv
`timescale 1ns/1ps
module test_axi_wstrb_narrower;
  logic clk;
  logic rst_n;
  int   n_chk;
  int   n_err;
  int   cyc;

  logic [3:0]  s_awid, m_awid;
  logic [31:0] s_awaddr, m_awaddr;
  logic [7:0]  s_awlen, m_awlen;
  logic [2:0]  s_awsize, m_awsize;
  logic [1:0]  s_awburst, m_awburst;
  logic        s_awvalid, s_awready, m_awvalid, m_awready;
  logic [31:0] s_wdata, m_wdata;
  logic [3:0]  s_wstrb, m_wstrb;
  logic        s_wlast, m_wlast, s_wvalid, s_wready, m_wvalid, m_wready;

  axi_wstrb_narrower i_axi_wstrb_narrower (
    .s_awid(s_awid), .s_awaddr(s_awaddr), .s_awlen(s_awlen), .s_awsize(s_awsize),
    .s_awburst(s_awburst), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast), .s_wvalid(s_wvalid),
    .s_wready(s_wready),
    .m_awid(m_awid), .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
    .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid),
    .m_wready(m_wready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  strb;
    logic [2:0]  size;
    logic [7:0]  len;
    logic [31:0] exp_addr;
    logic [2:0]  exp_size;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{32'h5550, 4'h1, 3'd2, 8'd0, 32'h5550, 3'd0, 4'd1},     // R1 lane 0
    '{32'h5550, 4'h2, 3'd2, 8'd0, 32'h5551, 3'd0, 4'd1},     // R1 lane 1
    '{32'h5550, 4'h4, 3'd2, 8'd0, 32'h5552, 3'd0, 4'd1},     // R1 lane 2
    '{32'h5550, 4'h8, 3'd2, 8'd0, 32'h5553, 3'd0, 4'd1},     // R1 lane 3
    '{32'h5550, 4'h3, 3'd2, 8'd0, 32'h5550, 3'd1, 4'd2},     // R2 low pair
    '{32'h5550, 4'hC, 3'd2, 8'd0, 32'h5552, 3'd1, 4'd2},     // R2 high pair
    '{32'h5550, 4'h0, 3'd2, 8'd0, 32'h5550, 3'd2, 4'd3},     // R3 empty
    '{32'h12345672, 4'h0, 3'd1, 8'd0, 32'h12345672, 3'd1, 4'd3}, // R3 other size
    '{32'h5550, 4'hF, 3'd2, 8'd0, 32'h5550, 3'd2, 4'd4},     // R4 full
    '{32'h5550, 4'h6, 3'd2, 8'd0, 32'h5550, 3'd2, 4'd4},     // R4 misaligned pair
    '{32'h5550, 4'h5, 3'd2, 8'd0, 32'h5550, 3'd2, 4'd4},     // R4 sparse
    '{32'h5550, 4'h7, 3'd2, 8'd0, 32'h5550, 3'd2, 4'd4},     // R4 three lanes
    '{32'h5553, 4'h2, 3'd2, 8'd0, 32'h5551, 3'd0, 4'd5},     // R5 replace not add
    '{32'hFFFFFFFC, 4'h8, 3'd2, 8'd0, 32'hFFFFFFFF, 3'd0, 4'd5}, // R5 top bits
    '{32'h5550, 4'h2, 3'd2, 8'd3, 32'h5550, 3'd2, 4'd9}      // R9 burst
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    s_awid = '0; s_awaddr = '0; s_awlen = '0; s_awsize = '0; s_awburst = '0;
    s_awvalid = 1'b0; s_wdata = '0; s_wstrb = '0; s_wlast = 1'b0; s_wvalid = 1'b0;
    m_awready = 1'b0; m_wready = 1'b0;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected<=5000", cyc);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    drive_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: idle inputs give idle outputs
    check("reset m_awvalid", 64'(m_awvalid), 64'd0);
    check("reset m_wvalid", 64'(m_wvalid), 64'd0);
    check("reset m_awaddr", 64'(m_awaddr), 64'd0);
    @(posedge clk);
    rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk);
      s_awaddr  = VECS[i].addr;
      s_wstrb   = VECS[i].strb;
      s_awsize  = VECS[i].size;
      s_awlen   = VECS[i].len;
      s_awvalid = 1'b1;
      s_wvalid  = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d addr", VECS[i].req, i), 64'(m_awaddr), 64'(VECS[i].exp_addr));
      check($sformatf("R%0d vec%0d size", VECS[i].req, i), 64'(m_awsize), 64'(VECS[i].exp_size));
    end

    // R6 and R7: all handshake combinations
    for (int c = 0; c < 16; c++) begin
      @(posedge clk);
      s_awvalid = c[0]; m_awready = c[1]; s_wvalid = c[2]; m_wready = c[3];
      @(negedge clk);
      check("R6 awvalid", 64'(m_awvalid), 64'(c[0]));
      check("R6 awready", 64'(s_awready), 64'(c[1]));
      check("R7 wvalid", 64'(m_wvalid), 64'(c[2]));
      check("R7 wready", 64'(s_wready), 64'(c[3]));
    end

    // R8: other fields pass unchanged
    @(posedge clk);
    s_awid = 4'hA; s_awlen = 8'd0; s_awburst = 2'b01; s_wdata = 32'hDEADBEEF;
    s_wstrb = 4'h4; s_wlast = 1'b1; s_awaddr = 32'h0000_1000; s_awsize = 3'd2;
    @(negedge clk);
    check("R8 awid", 64'(m_awid), 64'hA);
    check("R8 awlen", 64'(m_awlen), 64'd0);
    check("R8 awburst", 64'(m_awburst), 64'd1);
    check("R8 wdata", 64'(m_wdata), 64'hDEADBEEF);
    check("R8 wstrb", 64'(m_wstrb), 64'h4);
    check("R8 wlast", 64'(m_wlast), 64'd1);

    // R10: strobe change between clock edges is seen at once
    #0.5;
    s_wstrb = 4'hC;
    #0.5;
    check("R10 addr follows strobe", 64'(m_awaddr), 64'h1002);
    check("R10 size follows strobe", 64'(m_awsize), 64'd1);
    s_wstrb = 4'h1;
    #0.5;
    check("R10 addr second change", 64'(m_awaddr), 64'h1000);
    check("R10 size second change", 64'(m_awsize), 64'd0);

    // R9: burst with each single lane stays wide
    for (int b = 0; b < 4; b++) begin
      @(posedge clk);
      s_awlen = 8'd1; s_wstrb = 4'(1 << b); s_awaddr = 32'h2000; s_awsize = 3'd2;
      @(negedge clk);
      check("R9 burst addr", 64'(m_awaddr), 64'h2000);
      check("R9 burst size", 64'(m_awsize), 64'd2);
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule